// File: doc/BRIEF.md
# End-around-carry Fibonacci word scrambler pair

This block is a matched encoder and decoder for a word-wide link. The encoder holds two state words and two carry bits. For every message word it accepts, it forms a Fibonacci-style sum of its two state words and the carry fed back from the previous step, then adds the message word on top. The result is both the new leading state word and the word sent on the link. The carry out of the Fibonacci sum and the overflow of the message addition travel next to that word as two flag bits.

The decoder mirrors the encoder's state. It forms the same Fibonacci sum from its own copy of the state and recovers the message word by modular subtraction. It then compares the carries it derived locally with the two flags on the link. A disagreement on the message-overflow flag is reported for that word alone. A disagreement on the Fibonacci carry latches a sticky alarm. Because the carry is fed back, a corrupted link word upsets the decoder's later sums and tends to surface as a carry disagreement within a couple of words, instead of remaining a silent fixed offset.

The top module exposes the encoder's link output and the decoder's link input as separate ports, so that the surrounding link, or a bench, sits between them.

Top module: `efw_link_pair`

## Requirements
- R1: After a synchronous reset, both ends hold the seed (parameter SEED, default 16'h1D35) in both state words, with both carry bits clear. The link word reads SEED, the link flags and link valid read 0, and the decoder's outputs (message, valid, data mismatch, carry mismatch) read 0.
- R2: On a cycle where tx_valid and tx_ready are both 1, let S = X + Y + C, where X and Y are the encoder's state words and C its carry. The low 16 bits of S are s and bit 16 of S is the new C. In the next cycle, link_tx_word equals (s + tx_msg) mod 2^16, link_tx_c equals the new C, and link_tx_d equals bit 16 of s + tx_msg. link_tx_valid is 1 for exactly that one cycle. The new Y is the old X, and the new X is the link word.
- R3: On a cycle without such an acceptance, the encoder state, link word and link flags hold their values, and link_tx_valid is 0 in the next cycle.
- R4: tx_ready follows link_ready in the same cycle.
- R5: On a cycle with link_rx_valid = 1, the decoder forms s from its own state in the same way as R2. In the next cycle, rx_msg equals (link_rx_word − s) mod 2^16 and rx_valid is 1. On an undisturbed link, this is the message word the encoder accepted. rx_valid is 0 after a cycle without link_rx_valid.
- R6: For each received word, rx_data_mismatch is 1 exactly when the local borrow (link_rx_word < s) differs from link_rx_d.
- R7: rx_carry_mismatch becomes 1 in the cycle after a received word whose local Fibonacci carry differs from link_rx_c. It then stays 1 until reset.
- R8: On each received word, the decoder's new X is the received word, its new Y is its old X, and its new carry is the local Fibonacci carry. Its state is unchanged on cycles without link_rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Message word offered to the encoder |
| tx_ready | output | 1 | Encoder can accept a word this cycle |
| tx_msg | input | 16 | Message word to encode |
| link_ready | input | 1 | Link can take a word in the following cycle |
| link_tx_word | output | 16 | Scrambled word sent on the link |
| link_tx_c | output | 1 | Fibonacci carry sent with the word |
| link_tx_d | output | 1 | Message-overflow flag sent with the word |
| link_tx_valid | output | 1 | Link word is new this cycle |
| link_rx_word | input | 16 | Scrambled word received from the link |
| link_rx_c | input | 1 | Received Fibonacci carry |
| link_rx_d | input | 1 | Received message-overflow flag |
| link_rx_valid | input | 1 | Received word present this cycle |
| rx_msg | output | 16 | Recovered message word |
| rx_valid | output | 1 | Recovered word is new this cycle |
| rx_data_mismatch | output | 1 | Overflow flag disagreed for this word |
| rx_carry_mismatch | output | 1 | Sticky carry disagreement alarm |

## Verification
In back-to-back streaming, the encoder accepts a new word in the same cycle that the decoder consumes the previous link word. Corruption of the link word or of either flag is injected in exactly those cycles, so that a mismatch detection coincides with an encoder state update. The bench drives random valid and ready patterns with occasional corruption. It judges both ends every cycle against two independent reference models of the recurrence: one fed the clean messages, and one fed the corrupted link words.

// File: rtl/efw_pkg.sv
package efw_pkg;
    localparam int unsigned EFW_WORD_W = 16;
    localparam logic [EFW_WORD_W-1:0] EFW_SEED = 16'h1D35;
endpackage

// File: rtl/efw_fib_add.sv
module efw_fib_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] lead_i,
    input  logic [W-1:0] lag_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] full;
    always_comb begin
        full   = {1'b0, lead_i} + {1'b0, lag_i} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
    end
endmodule

// File: rtl/efw_encoder.sv
module efw_encoder #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] SEED = 16'h1D35
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_msg,
    input  logic         link_ready,
    output logic [W-1:0] out_word,
    output logic         out_c,
    output logic         out_d,
    output logic         out_valid
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         c;
        logic         d;
        logic         v;
    } enc_st_t;

    enc_st_t st_d, st_q;
    logic [W-1:0] fib_sum;
    logic         fib_carry;
    logic [W:0]   msg_sum;
    logic         accept;

    efw_fib_add #(.W(W)) u_fib (
        .lead_i (st_q.x),
        .lag_i  (st_q.y),
        .cin_i  (st_q.c),
        .sum_o  (fib_sum),
        .cout_o (fib_carry)
    );

    always_comb begin
        in_ready = link_ready;
        accept   = in_valid && link_ready;
        msg_sum  = {1'b0, fib_sum} + {1'b0, in_msg};
        st_d     = st_q;
        st_d.v   = 1'b0;
        if (accept) begin
            st_d.x = msg_sum[W-1:0];
            st_d.y = st_q.x;
            st_d.c = fib_carry;
            st_d.d = msg_sum[W];
            st_d.v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.x <= SEED;
            st_q.y <= SEED;
            st_q.c <= 1'b0;
            st_q.d <= 1'b0;
            st_q.v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_word  = st_q.x;
    assign out_c     = st_q.c;
    assign out_d     = st_q.d;
    assign out_valid = st_q.v;

    a_r3_hold_state: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && link_ready) |=> ($stable(st_q.x) && $stable(st_q.y) && $stable(st_q.c) && !st_q.v));
    a_r2_shift_lag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && link_ready) |=> (st_q.y == $past(st_q.x) && st_q.v));
endmodule

// File: rtl/efw_decoder.sv
module efw_decoder #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] SEED = 16'h1D35
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    input  logic         in_c,
    input  logic         in_d,
    output logic [W-1:0] msg_out,
    output logic         msg_valid,
    output logic         data_mis,
    output logic         carry_mis
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         c;
        logic         d;
        logic [W-1:0] msg;
        logic         mv;
        logic         dm;
        logic         cm;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [W-1:0] pred;
    logic         pred_carry;
    logic         borrow;

    efw_fib_add #(.W(W)) u_fib (
        .lead_i (st_q.x),
        .lag_i  (st_q.y),
        .cin_i  (st_q.c),
        .sum_o  (pred),
        .cout_o (pred_carry)
    );

    always_comb begin
        borrow  = (in_word < pred);
        st_d    = st_q;
        st_d.mv = 1'b0;
        if (in_valid) begin
            st_d.x   = in_word;
            st_d.y   = st_q.x;
            st_d.c   = pred_carry;
            st_d.d   = borrow;
            st_d.msg = in_word - pred;
            st_d.mv  = 1'b1;
            st_d.dm  = (borrow != in_d);
            st_d.cm  = st_q.cm | (pred_carry != in_c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.x   <= SEED;
            st_q.y   <= SEED;
            st_q.c   <= 1'b0;
            st_q.d   <= 1'b0;
            st_q.msg <= '0;
            st_q.mv  <= 1'b0;
            st_q.dm  <= 1'b0;
            st_q.cm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_out   = st_q.msg;
    assign msg_valid = st_q.mv;
    assign data_mis  = st_q.dm;
    assign carry_mis = st_q.cm;

    a_r7_sticky_alarm: assert property (@(posedge clk) disable iff (rst)
        st_q.cm |=> st_q.cm);
    a_r8_shift_lag: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (st_q.y == $past(st_q.x) && st_q.x == $past(in_word)));
    a_r8_hold_state: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(st_q.x) && $stable(st_q.y) && $stable(st_q.c)));
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> msg_valid);
endmodule

// File: rtl/efw_link_pair.sv
module efw_link_pair #(
    parameter int unsigned W = efw_pkg::EFW_WORD_W,
    parameter logic [W-1:0] SEED = efw_pkg::EFW_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_valid,
    output logic         tx_ready,
    input  logic [W-1:0] tx_msg,
    input  logic         link_ready,
    output logic [W-1:0] link_tx_word,
    output logic         link_tx_c,
    output logic         link_tx_d,
    output logic         link_tx_valid,
    input  logic [W-1:0] link_rx_word,
    input  logic         link_rx_c,
    input  logic         link_rx_d,
    input  logic         link_rx_valid,
    output logic [W-1:0] rx_msg,
    output logic         rx_valid,
    output logic         rx_data_mismatch,
    output logic         rx_carry_mismatch
);
    efw_encoder #(.W(W), .SEED(SEED)) u_enc (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (tx_valid),
        .in_ready   (tx_ready),
        .in_msg     (tx_msg),
        .link_ready (link_ready),
        .out_word   (link_tx_word),
        .out_c      (link_tx_c),
        .out_d      (link_tx_d),
        .out_valid  (link_tx_valid)
    );

    efw_decoder #(.W(W), .SEED(SEED)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (link_rx_valid),
        .in_word   (link_rx_word),
        .in_c      (link_rx_c),
        .in_d      (link_rx_d),
        .msg_out   (rx_msg),
        .msg_valid (rx_valid),
        .data_mis  (rx_data_mismatch),
        .carry_mis (rx_carry_mismatch)
    );

    a_r4_ready_follows: assert property (@(posedge clk) disable iff (rst)
        tx_ready == link_ready);
endmodule

// File: tb/sim_efw_link_pair.sv
`timescale 1ns/1ps
module sim_efw_link_pair;
    localparam logic [15:0] SEED = 16'h1D35;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0, link_ready = 1'b0;
    logic [15:0] tx_msg = '0;
    logic tx_ready;
    logic [15:0] link_tx_word, rx_msg;
    logic link_tx_c, link_tx_d, link_tx_valid;
    logic rx_valid, rx_dm, rx_cm;
    logic [15:0] inj_mask = '0;
    logic inj_c = 1'b0, inj_d = 1'b0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    efw_link_pair u0 (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
        .link_ready(link_ready), .link_tx_word(link_tx_word), .link_tx_c(link_tx_c),
        .link_tx_d(link_tx_d), .link_tx_valid(link_tx_valid),
        .link_rx_word(link_tx_word ^ inj_mask), .link_rx_c(link_tx_c ^ inj_c),
        .link_rx_d(link_tx_d ^ inj_d), .link_rx_valid(link_tx_valid),
        .rx_msg(rx_msg), .rx_valid(rx_valid), .rx_data_mismatch(rx_dm),
        .rx_carry_mismatch(rx_cm)
    );

    // reference models
    logic [15:0] ex, ey, dx, dy, last_msg;
    logic ec, ed, dc, lv, dirty;
    logic [15:0] e_msg, e_orig;
    logic e_mv, e_dm, e_cm, e_clean;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ex = SEED; ey = SEED; ec = 1'b0; ed = 1'b0;
        dx = SEED; dy = SEED; dc = 1'b0;
        lv = 1'b0; dirty = 1'b0; last_msg = '0;
        e_msg = '0; e_mv = 1'b0; e_dm = 1'b0; e_cm = 1'b0; e_clean = 1'b0; e_orig = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_valid = 1'b0; link_ready = 1'b0;
        inj_mask = '0; inj_c = 1'b0; inj_d = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state at the ports
        chk("R1 link_word", {16'h0, link_tx_word}, {16'h0, SEED});
        chk("R1 link_c", {31'h0, link_tx_c}, 0);
        chk("R1 link_d", {31'h0, link_tx_d}, 0);
        chk("R1 link_valid", {31'h0, link_tx_valid}, 0);
        chk("R1 rx_valid", {31'h0, rx_valid}, 0);
        chk("R1 rx_msg", {16'h0, rx_msg}, 0);
        chk("R1 data_mismatch", {31'h0, rx_dm}, 0);
        chk("R1 carry_mismatch", {31'h0, rx_cm}, 0);
    endtask

    // one clock: called just after a negedge
    task automatic step(input logic v, input logic [15:0] m, input logic rdy,
                        input logic [15:0] wmask, input logic cf, input logic df);
        logic [16:0] t;
        logic [15:0] s, w;
        logic co, acc;
        tx_valid = v; tx_msg = m; link_ready = rdy;
        inj_mask = wmask; inj_c = cf; inj_d = df;
        #1;
        chk("R4 tx_ready", {31'h0, tx_ready}, {31'h0, rdy});
        if (lv) begin
            w = ex ^ wmask;
            t = {1'b0, dx} + {1'b0, dy} + {16'h0, dc};
            s = t[15:0]; co = t[16];
            e_msg = w - s;
            e_mv = 1'b1;
            e_dm = ((w < s) != (ed ^ df));
            e_cm = e_cm | (co != (ec ^ cf));
            if (wmask != 0 || cf || df) dirty = 1'b1;
            e_clean = !dirty;
            e_orig = last_msg;
            dy = dx; dx = w; dc = co;
        end else begin
            e_mv = 1'b0;
        end
        acc = v && rdy;
        if (acc) begin
            t = {1'b0, ex} + {1'b0, ey} + {16'h0, ec};
            s = t[15:0]; co = t[16];
            t = {1'b0, s} + {1'b0, m};
            ey = ex; ex = t[15:0]; ec = co; ed = t[16];
            last_msg = m;
        end
        lv = acc;
        @(posedge clk); @(negedge clk);
        if (acc) begin
            chk("R2 link_valid", {31'h0, link_tx_valid}, 1);
            chk("R2 link_word", {16'h0, link_tx_word}, {16'h0, ex});
            chk("R2 link_c", {31'h0, link_tx_c}, {31'h0, ec});
            chk("R2 link_d", {31'h0, link_tx_d}, {31'h0, ed});
        end else begin
            chk("R3 link_valid", {31'h0, link_tx_valid}, 0);
            chk("R3 link_word held", {16'h0, link_tx_word}, {16'h0, ex});
            chk("R3 link_c held", {31'h0, link_tx_c}, {31'h0, ec});
        end
        chk("R5 rx_valid", {31'h0, rx_valid}, {31'h0, e_mv});
        if (e_mv) begin
            chk("R5/R8 rx_msg", {16'h0, rx_msg}, {16'h0, e_msg});
            if (e_clean) chk("R5 end-to-end message", {16'h0, rx_msg}, {16'h0, e_orig});
            chk("R6 data_mismatch", {31'h0, rx_dm}, {31'h0, e_dm});
        end
        chk("R7 carry_mismatch", {31'h0, rx_cm}, {31'h0, e_cm});
        inj_mask = '0; inj_c = 1'b0; inj_d = 1'b0;
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        do_reset();

        // directed: zero words, stalls, blocked by link_ready (R3, R4)
        for (int i = 0; i < 3; i++) step(1'b1, 16'h0000, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b0, 16'hAAAA, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'h5555, 1'b0, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'hFFFF, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'hFFFF, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0);

        // random clean traffic, back-to-back and with gaps
        for (int i = 0; i < 1500; i++)
            step(($urandom % 4) != 0, 16'($urandom), ($urandom % 5) != 0, 16'h0, 1'b0, 1'b0);
        step(1'b0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0);

        // R6: flipped overflow flag is flagged for that word only
        step(1'b1, 16'h1234, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'h4321, 1'b1, 16'h0, 1'b0, 1'b1);
        chk("R6 forced flag flip", {31'h0, rx_dm}, 1);
        step(1'b0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0);
        chk("R6 next word clean", {31'h0, rx_dm}, 0);

        // R7: flipped carry latches the alarm, which survives clean words
        step(1'b1, 16'h0F0F, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'h0000, 1'b1, 16'h0, 1'b1, 1'b0);
        chk("R7 forced carry flip", {31'h0, rx_cm}, 1);
        for (int i = 0; i < 6; i++) step(1'b1, 16'h0000, 1'b1, 16'h0, 1'b0, 1'b0);
        chk("R7 alarm still set", {31'h0, rx_cm}, 1);
        do_reset();

        // single bit flip into an all-zero message stream
        for (int i = 0; i < 10; i++) step(1'b1, 16'h0000, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'h0000, 1'b1, 16'h0200, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 16'h0000, 1'b1, 16'h0, 1'b0, 1'b0);
        do_reset();

        // constant message with a flipped bit
        for (int i = 0; i < 8; i++) step(1'b1, 16'h4000, 1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, 16'h4000, 1'b1, 16'h8000, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 16'h4000, 1'b1, 16'h0, 1'b0, 1'b0);
        do_reset();

        // streaming with corruption landing on encoder acceptance cycles
        for (int i = 0; i < 1000; i++) begin
            logic inj;
            inj = ($urandom % 60) == 0;
            step(($urandom % 8) != 0, 16'($urandom), 1'b1,
                 inj ? (16'h1 << ($urandom % 16)) : 16'h0,
                 (($urandom % 200) == 0), (($urandom % 150) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule